// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block chooses one interrupt to hand to the processor core at each instruction boundary. It takes one non-maskable request and a set of maskable sources. Each maskable source has a condition line, an enable bit and a one-bit priority level. Two processor mask bits, I and UI, work as a pair and give three levels of masking. Level-1 sources can get past a mask that blocks level-0 sources. A single setting of both bits blocks everything except the non-maskable request.

The core pulses `insn_done` when an instruction finishes. If an eligible request exists in that cycle, the block raises `irq_take` for one cycle on the following clock, together with the vector number of the winner. In the same clock it raises I. When a level-1 source is taken while I is already set, it also raises UI, so that a second level-1 source cannot nest. The block does not latch a request that it does not take. A request that stays asserted is considered again at every later boundary. Software restores the mask bits through a load strobe.

Top module: `icu_two_level`

## Requirements
- R1: A maskable source requests only while both its condition line and its enable bit are 1. A source with either bit at 0 is never taken.
- R2: Among eligible requests, a source with level bit 1 beats any source with level bit 0, whatever their indices.
- R3: Among eligible requests of the same level, the source with the lowest index wins.
- R4: With I=0, every maskable request is eligible.
- R5: With I=1 and UI=0, only the non-maskable request and level-1 sources are eligible.
- R6: With I=1 and UI=1, only the non-maskable request is eligible.
- R7: The non-maskable request is never masked and beats every maskable source.
- R8: A request is taken only at a boundary. If `insn_done` is 1 in cycle n and a request is eligible, `irq_take` is 1 in cycle n+1 for that one cycle. In every other cycle `irq_take` is 0.
- R9: In the cycle `irq_take` is 1, `mask_i` reads 1.
- R10: In the cycle `irq_take` is 1, `irq_vec` holds the winner's vector: NMI_VEC (default 7) for the non-maskable request, and VEC_BASE+k (default 16+k) for source k.
- R11: Taking a level-1 source while I was 1 sets UI to 1. Any other take leaves UI as it was.
- R12: A request that is not taken stays eligible for later boundaries and is taken once the masks allow it. A mask load (`mask_ld`=1) copies `mask_ld_i`/`mask_ld_ui` into I/UI on the next clock, unless a take happens in that same clock, in which case the take's update wins.
- R13: During and right after reset, I=1, UI=1 and `irq_take`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| src_cond | input | N_SRC | Interrupt condition of each maskable source |
| src_en | input | N_SRC | Enable bit of each maskable source |
| src_lvl | input | N_SRC | Priority level bit of each source (1 = high) |
| nmi_req | input | 1 | Non-maskable request |
| insn_done | input | 1 | Instruction-complete strobe |
| mask_ld | input | 1 | Load strobe for the mask bits |
| mask_ld_i | input | 1 | Value of I to load |
| mask_ld_ui | input | 1 | Value of UI to load |
| mask_i | output | 1 | Current I mask bit |
| mask_ui | output | 1 | Current UI mask bit |
| irq_take | output | 1 | One-cycle accept pulse |
| irq_vec | output | VEC_W | Vector number of the accepted request |

## Verification
The hardest case to reach is the take that raises UI. A level-1 source must win while I is already 1 and UI is 0, which needs a prior take or mask load to leave that exact pair. A second case is a mask load that arrives in the same clock as a take. The bench reaches both by loading the masks explicitly and then firing a boundary with a level-0 and a level-1 request raised together. It also loads the masks and takes a request in one cycle. A long phase of random source, mask-load and boundary patterns then visits the three mask states many times over. A behavioural model is compared with the outputs on every clock.

// File: rtl/icu_pkg.sv
package icu_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_NMI  = 2'd1,
    WIN_HI   = 2'd2,
    WIN_LO   = 2'd3
  } win_kind_e;
endpackage

// File: rtl/icu_req_gate.sv
module icu_req_gate #(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0] src_cond,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic             mask_i,
  input  logic             mask_ui,
  output logic [N_SRC-1:0] elig_hi,
  output logic [N_SRC-1:0] elig_lo
);
  logic hi_open;
  logic lo_open;

  // level 1 passes unless both bits are set, level 0 only while I is clear
  assign hi_open = ~(mask_i & mask_ui);
  assign lo_open = ~mask_i;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic raised;
    assign raised     = src_cond[k] & src_en[k];
    assign elig_hi[k] = raised &  src_lvl[k] & hi_open;
    assign elig_lo[k] = raised & ~src_lvl[k] & lo_open;
  end
endmodule

// File: rtl/icu_ffs.sv
module icu_ffs #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] vec_in,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (vec_in[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/icu_mask_ctl.sv
module icu_mask_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic ld,
  input  logic ld_i,
  input  logic ld_ui,
  output logic mask_i,
  output logic mask_ui
);
  logic i_q, ui_q;
  logic i_d, ui_d;
  logic upd;

  always_comb begin
    i_d  = i_q;
    ui_d = ui_q;
    if (take) begin
      i_d  = 1'b1;
      ui_d = ui_q | (take_hi & i_q);
    end else if (ld) begin
      i_d  = ld_i;
      ui_d = ld_ui;
    end
  end

  assign upd = take | ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_q  <= 1'b1;
      ui_q <= 1'b1;
    end else if (upd) begin
      i_q  <= i_d;
      ui_q <= ui_d;
    end
  end

  assign mask_i  = i_q;
  assign mask_ui = ui_q;
endmodule

// File: rtl/icu_two_level.sv
module icu_two_level #(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int NMI_VEC  = 7,
  parameter int VEC_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_cond,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic             nmi_req,
  input  logic             insn_done,
  input  logic             mask_ld,
  input  logic             mask_ld_i,
  input  logic             mask_ld_ui,
  output logic             mask_i,
  output logic             mask_ui,
  output logic             irq_take,
  output logic [VEC_W-1:0] irq_vec
);
  import icu_pkg::*;

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(NMI_VEC);
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);

  logic [N_SRC-1:0] elig_hi, elig_lo;
  logic             hi_found, lo_found;
  logic [IDX_W-1:0] hi_idx, lo_idx;
  win_kind_e        win;
  logic [IDX_W-1:0] win_idx;
  logic [VEC_W-1:0] vec_d;
  logic             take_d;
  logic             take_q;
  logic [VEC_W-1:0] vec_q;

  icu_req_gate #(.N_SRC(N_SRC)) u_gate (
    .src_cond (src_cond),
    .src_en   (src_en),
    .src_lvl  (src_lvl),
    .mask_i   (mask_i),
    .mask_ui  (mask_ui),
    .elig_hi  (elig_hi),
    .elig_lo  (elig_lo)
  );

  icu_ffs #(.N_SRC(N_SRC)) u_pick_hi (
    .vec_in (elig_hi),
    .found  (hi_found),
    .idx    (hi_idx)
  );

  icu_ffs #(.N_SRC(N_SRC)) u_pick_lo (
    .vec_in (elig_lo),
    .found  (lo_found),
    .idx    (lo_idx)
  );

  // fixed ranking: NMI, then level 1, then level 0
  always_comb begin
    win     = WIN_NONE;
    win_idx = '0;
    if (nmi_req) begin
      win = WIN_NMI;
    end else if (hi_found) begin
      win     = WIN_HI;
      win_idx = hi_idx;
    end else if (lo_found) begin
      win     = WIN_LO;
      win_idx = lo_idx;
    end
  end

  always_comb begin
    take_d = insn_done & (win != WIN_NONE);
    if (win == WIN_NMI) vec_d = NMI_V;
    else                vec_d = BASE_V + VEC_W'(win_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= take_d;
      if (take_d) vec_q <= vec_d;
    end
  end

  icu_mask_ctl u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take_d),
    .take_hi (win == WIN_HI),
    .ld      (mask_ld),
    .ld_i    (mask_ld_i),
    .ld_ui   (mask_ld_ui),
    .mask_i  (mask_i),
    .mask_ui (mask_ui)
  );

  assign irq_take = take_q;
  assign irq_vec  = vec_q;
endmodule

// File: rtl/icu_two_level_chk.sv
module icu_two_level_chk #(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int NMI_VEC  = 7,
  parameter int VEC_BASE = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_cond,
  input logic [N_SRC-1:0] src_en,
  input logic [N_SRC-1:0] src_lvl,
  input logic             nmi_req,
  input logic             insn_done,
  input logic             mask_ld,
  input logic             mask_i,
  input logic             mask_ui,
  input logic             irq_take,
  input logic [VEC_W-1:0] irq_vec
);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);
  localparam logic [VEC_W-1:0] LO_V  = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] HI_V  = VEC_W'(VEC_BASE + N_SRC);

  logic [N_SRC-1:0] raised;
  assign raised = src_cond & src_en;

  AST_NONE_RAISED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !nmi_req && raised == '0) |=> !irq_take); // R1

  AST_OPEN_MASK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !mask_i && raised != '0) |=> irq_take); // R4

  AST_MID_MASK_BLOCKS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !nmi_req && mask_i && !mask_ui && (raised & src_lvl) == '0) |=> !irq_take); // R5

  AST_FULL_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !nmi_req && mask_i && mask_ui) |=> !irq_take); // R6

  AST_NMI_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && nmi_req) |=> (irq_take && irq_vec == NMI_V)); // R7

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(insn_done)); // R8

  AST_TAKE_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> mask_i); // R9

  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_vec == NMI_V || (irq_vec >= LO_V && irq_vec < HI_V))); // R10

  AST_UI_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_ui) |-> (irq_take || $past(mask_ld))); // R11
endmodule

bind icu_two_level icu_two_level_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .NMI_VEC(NMI_VEC), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_cond(src_cond), .src_en(src_en),
  .src_lvl(src_lvl), .nmi_req(nmi_req), .insn_done(insn_done),
  .mask_ld(mask_ld), .mask_i(mask_i), .mask_ui(mask_ui),
  .irq_take(irq_take), .irq_vec(irq_vec)
);

// File: tb/tb_icu_two_level.sv
module tb_icu_two_level;
  localparam int N = 8;
  localparam int NMI_V = 7;
  localparam int BASE = 16;

  logic clk, rst_n;
  logic [N-1:0] src_cond, src_en, src_lvl;
  logic nmi_req, insn_done, mask_ld, mask_ld_i, mask_ld_ui;
  logic mask_i, mask_ui, irq_take;
  logic [7:0] irq_vec;

  int total = 0;
  int fails = 0;

  icu_two_level dut (
    .clk(clk), .rst_n(rst_n), .src_cond(src_cond), .src_en(src_en),
    .src_lvl(src_lvl), .nmi_req(nmi_req), .insn_done(insn_done),
    .mask_ld(mask_ld), .mask_ld_i(mask_ld_i), .mask_ld_ui(mask_ld_ui),
    .mask_i(mask_i), .mask_ui(mask_ui), .irq_take(irq_take), .irq_vec(irq_vec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, stepped on each rising edge
  int m_i, m_ui, m_acc, m_vec;
  always @(posedge clk) begin
    int found, hi, v;
    if (!rst_n) begin
      m_i = 1; m_ui = 1; m_acc = 0; m_vec = 0;
    end else begin
      found = 0; hi = 0; v = 0;
      if (nmi_req) begin
        found = 1; v = NMI_V;
      end else begin
        if (!(m_i == 1 && m_ui == 1))
          for (int k = 0; k < N; k++)
            if (!found && src_cond[k] && src_en[k] && src_lvl[k]) begin
              found = 1; hi = 1; v = BASE + k;
            end
        if (!found && m_i == 0)
          for (int k = 0; k < N; k++)
            if (!found && src_cond[k] && src_en[k] && !src_lvl[k]) begin
              found = 1; v = BASE + k;
            end
      end
      m_acc = (insn_done && found) ? 1 : 0;
      if (m_acc == 1) begin
        m_vec = v;
        if (hi == 1 && m_i == 1) m_ui = 1;
        m_i = 1;
      end else if (mask_ld) begin
        m_i = int'(mask_ld_i); m_ui = int'(mask_ld_ui);
      end
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R8 model take", int'(irq_take), m_acc);
      if (m_acc == 1) chk("R10 model vector", int'(irq_vec), m_vec);
      chk("R9 model I", int'(mask_i), m_i);
      chk("R11 model UI", int'(mask_ui), m_ui);
    end
  end

  task automatic set_src(input logic [N-1:0] c, input logic [N-1:0] e, input logic [N-1:0] l);
    src_cond = c; src_en = e; src_lvl = l;
  endtask

  task automatic load_mask(input logic i, input logic ui);
    @(negedge clk); mask_ld = 1'b1; mask_ld_i = i; mask_ld_ui = ui;
    @(negedge clk); mask_ld = 1'b0;
  endtask

  // strobe one boundary; returns at the negedge where results are visible
  task automatic boundary();
    @(negedge clk); insn_done = 1'b1;
    @(negedge clk); insn_done = 1'b0;
  endtask

  initial begin
    int seed;
    rst_n = 1'b0; insn_done = 1'b0; nmi_req = 1'b0;
    mask_ld = 1'b0; mask_ld_i = 1'b0; mask_ld_ui = 1'b0;
    set_src('0, '0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R13 reset I", int'(mask_i), 1);
    chk("R13 reset UI", int'(mask_ui), 1);
    chk("R13 reset take", int'(irq_take), 0);
    cmp_on = 1;

    // R4: open mask, single level-0 source
    load_mask(1'b0, 1'b0);
    set_src(8'h08, 8'hFF, 8'h00);
    boundary();
    chk("R4 take", int'(irq_take), 1);
    chk("R10 vector src3", int'(irq_vec), 19);
    chk("R9 I set", int'(mask_i), 1);
    chk("R11 UI kept", int'(mask_ui), 0);

    // R1: condition without enable is ignored
    load_mask(1'b0, 1'b0);
    set_src(8'h24, 8'h20, 8'h00);
    boundary();
    chk("R1 vector src5", int'(irq_vec), 21);

    // R8: no boundary, no take
    load_mask(1'b0, 1'b0);
    set_src(8'h01, 8'h01, 8'h00);
    repeat (4) begin
      @(negedge clk);
      chk("R8 idle take", int'(irq_take), 0);
    end

    // R2: level 1 beats lower index
    set_src(8'h42, 8'hFF, 8'h40);
    boundary();
    chk("R2 vector src6", int'(irq_vec), 22);

    // R3: tie within level -> lowest index
    load_mask(1'b0, 1'b0);
    set_src(8'h14, 8'hFF, 8'h14);
    boundary();
    chk("R3 vector src2", int'(irq_vec), 18);

    // R5 + R11: I=1 UI=0, level 1 taken and UI rises
    load_mask(1'b1, 1'b0);
    set_src(8'h81, 8'hFF, 8'h80);
    boundary();
    chk("R5 vector src7", int'(irq_vec), 23);
    chk("R11 UI raised", int'(mask_ui), 1);

    // R5 blocks level 0, R12 pending taken later
    load_mask(1'b1, 1'b0);
    set_src(8'h01, 8'hFF, 8'h00);
    boundary();
    chk("R5 level0 blocked", int'(irq_take), 0);
    load_mask(1'b0, 1'b0);
    boundary();
    chk("R12 pending taken", int'(irq_take), 1);
    chk("R12 pending vector", int'(irq_vec), 16);

    // R6: full mask blocks level 1, NMI passes (R7), UI stays
    load_mask(1'b1, 1'b1);
    set_src(8'h02, 8'hFF, 8'h02);
    boundary();
    chk("R6 level1 blocked", int'(irq_take), 0);
    nmi_req = 1'b1;
    boundary();
    nmi_req = 1'b0;
    chk("R7 nmi taken", int'(irq_take), 1);
    chk("R7 nmi vector", int'(irq_vec), NMI_V);
    chk("R11 UI after nmi", int'(mask_ui), 1);

    // R7: NMI beats level 1 under open mask
    load_mask(1'b0, 1'b0);
    set_src(8'h01, 8'hFF, 8'h01);
    nmi_req = 1'b1;
    boundary();
    nmi_req = 1'b0;
    chk("R7 nmi over src0", int'(irq_vec), NMI_V);
    chk("R11 UI open nmi", int'(mask_ui), 0);

    // R12: take wins over a same-cycle mask load
    load_mask(1'b0, 1'b0);
    set_src(8'h10, 8'hFF, 8'h00);
    @(negedge clk); insn_done = 1'b1; mask_ld = 1'b1; mask_ld_i = 1'b0; mask_ld_ui = 1'b0;
    @(negedge clk); insn_done = 1'b0; mask_ld = 1'b0;
    chk("R12 take over load I", int'(mask_i), 1);
    chk("R12 take vector", int'(irq_vec), 20);

    // random phase, checked against the model on every clock
    seed = 17;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      src_cond   = N'($urandom(seed + n));
      src_en     = N'($urandom());
      src_lvl    = N'($urandom());
      nmi_req    = ($urandom() % 16) == 0;
      insn_done  = ($urandom() % 2) == 0;
      mask_ld    = ($urandom() % 5) == 0;
      mask_ld_i  = ($urandom() % 2) == 0;
      mask_ld_ui = ($urandom() % 2) == 0;
    end
    @(negedge clk);
    insn_done = 1'b0; mask_ld = 1'b0; nmi_req = 1'b0;
    @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule